// File: doc/BRIEF.md
# Debounced Unlock Event Interval Counter

This block watches a lock status line and counts how often the lock is lost. The line is high while locked and pulled low on loss of lock; each high-to-low transition is one unlock event. A contact-style holdoff follows every accepted event, so a burst of chatter counts once. Each accepted event adds one to a count for the current reporting window and one to a total that is never cleared.

A one-minute tick advances a clock of minutes and hours. A separate minute count within the window tells when the window closes. When it closes, the block offers a record on a valid/ready output. The record holds the window's event count, the total, and the hours and minutes at the close. The window count then restarts from zero. The block is used to get a relative figure for how often a clock recovery loop drops out over time.

Top module: `unlock_event_logger`

## Requirements
- R1: After reset no record is offered (`rec_valid` low). A lock line that stays high counts no events.
- R2: Each 1-to-0 transition of `lock_in`, after a two-flop synchronizer, is one unlock event. A 0-to-1 transition counts nothing.
- R3: After an accepted event, transitions are ignored for DEBOUNCE_MS * (CLK_HZ/1000) clock cycles.
- R4: Each accepted event adds one to both the window count and the running total.
- R5: On every INTERVAL_MIN-th `min_tick` pulse a record is produced. It carries the window count, including any event accepted in that cycle. The window count then restarts at 0 and the total is kept.
- R6: The minutes field runs 0 to 59. The tick that would make it 60 sets it to 0 and adds one to the hours. Each record carries the time after its closing tick.
- R7: The window count and the total stop at 2^CNT_W-1 and do not wrap. Hours stop at 2^HOUR_W-1.
- R8: A record stays offered with all fields stable until `rec_ready` is high. A window that closes while a record is still pending is discarded, but its count is still cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_in | input | 1 | Asynchronous lock status, 1 = locked, 0 = unlocked |
| min_tick | input | 1 | One-cycle pulse once per minute |
| rec_ready | input | 1 | Consumer accepts the offered record |
| rec_valid | output | 1 | A record is offered |
| rec_interval | output | CNT_W | Events in the closed window |
| rec_total | output | CNT_W | Events since reset |
| rec_hours | output | HOUR_W | Elapsed hours at window close |
| rec_minutes | output | 6 | Elapsed minutes (0 to 59) at window close |

## Verification
The assertions check on every cycle that a pending record holds still until it is taken. They also check that a record appears only on a minute tick, that the minutes field stays below 60, that the total never falls below the window count, and that a taken record is withdrawn. Other behaviours show only in the bench's scenarios: chatter collapsing into one event, window counts clearing while the total carries on, saturation, the hour rollover, and a window discarded while a record waits. The scoreboard compares each record with a model of those rules.

// File: rtl/unlock_event_logger.sv
module unlock_event_logger #(
  parameter int CLK_HZ       = 125_000_000,
  parameter int DEBOUNCE_MS  = 20,
  parameter int INTERVAL_MIN = 10,
  parameter int CNT_W        = 16,
  parameter int HOUR_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_in,
  input  logic              min_tick,
  input  logic              rec_ready,
  output logic              rec_valid,
  output logic [CNT_W-1:0]  rec_interval,
  output logic [CNT_W-1:0]  rec_total,
  output logic [HOUR_W-1:0] rec_hours,
  output logic [5:0]        rec_minutes
);
  localparam int DB_CYCLES = (CLK_HZ / 1000) * DEBOUNCE_MS;
  localparam int HOLD_W    = $clog2(DB_CYCLES + 1);
  localparam int IMIN_W    = $clog2(INTERVAL_MIN + 1);
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
  localparam logic [HOUR_W-1:0] HOUR_MAX = '1;

  logic [2:0]        sync;
  logic [HOLD_W-1:0] hold;
  logic [CNT_W-1:0]  win_cnt, tot_cnt, win_nx, tot_nx;
  logic [5:0]        minutes, min_nx;
  logic [HOUR_W-1:0] hours, hr_nx;
  logic [IMIN_W-1:0] imin;
  logic              fall, accept, min_wrap, boundary, load;

  assign fall     = sync[2] & ~sync[1];
  assign accept   = fall && (hold == '0);
  assign win_nx   = (accept && win_cnt != CNT_MAX) ? win_cnt + 1'b1 : win_cnt;
  assign tot_nx   = (accept && tot_cnt != CNT_MAX) ? tot_cnt + 1'b1 : tot_cnt;
  assign min_wrap = min_tick && (minutes == 6'd59);
  assign min_nx   = !min_tick ? minutes : (min_wrap ? 6'd0 : minutes + 6'd1);
  assign hr_nx    = (min_wrap && hours != HOUR_MAX) ? hours + 1'b1 : hours;
  assign boundary = min_tick && (imin == IMIN_W'(INTERVAL_MIN - 1));
  assign load     = boundary && (!rec_valid || rec_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync    <= 3'b111;
      hold    <= '0;
      win_cnt <= '0;
      tot_cnt <= '0;
      minutes <= '0;
      hours   <= '0;
      imin    <= '0;
    end else begin
      sync    <= {sync[1:0], lock_in};
      if (accept)            hold <= HOLD_W'(DB_CYCLES);
      else if (hold != '0)   hold <= hold - 1'b1;
      win_cnt <= boundary ? '0 : win_nx;
      tot_cnt <= tot_nx;
      minutes <= min_nx;
      hours   <= hr_nx;
      if (min_tick) imin <= boundary ? '0 : imin + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_valid    <= 1'b0;
      rec_interval <= '0;
      rec_total    <= '0;
      rec_hours    <= '0;
      rec_minutes  <= '0;
    end else if (load) begin
      rec_valid    <= 1'b1;
      rec_interval <= win_nx;
      rec_total    <= tot_nx;
      rec_hours    <= hr_nx;
      rec_minutes  <= min_nx;
    end else if (rec_ready) begin
      rec_valid    <= 1'b0;
    end
  end
endmodule

module unlock_event_logger_chk #(
  parameter int CNT_W  = 16,
  parameter int HOUR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              min_tick,
  input logic              rec_ready,
  input logic              rec_valid,
  input logic [CNT_W-1:0]  rec_interval,
  input logic [CNT_W-1:0]  rec_total,
  input logic [HOUR_W-1:0] rec_hours,
  input logic [5:0]        rec_minutes
);
  assert_held_until_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_interval) && $stable(rec_total)
                                && $stable(rec_hours) && $stable(rec_minutes));
  assert_withdrawn_after_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && rec_ready && !min_tick |=> !rec_valid);
  assert_record_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rec_valid) |-> $past(min_tick));
  assert_minutes_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> rec_minutes < 6'd60);
  assert_total_covers_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> rec_total >= rec_interval);
endmodule

bind unlock_event_logger unlock_event_logger_chk #(.CNT_W(CNT_W), .HOUR_W(HOUR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .min_tick(min_tick), .rec_ready(rec_ready),
  .rec_valid(rec_valid), .rec_interval(rec_interval), .rec_total(rec_total),
  .rec_hours(rec_hours), .rec_minutes(rec_minutes));

// File: tb/test_unlock_event_logger.sv
module test_unlock_event_logger;
  localparam int CNT_W = 4, HOUR_W = 4, IVL = 3;
  logic clk = 0, rst_n = 0, lock_in = 1, min_tick = 0, rec_ready = 1;
  logic rec_valid;
  logic [CNT_W-1:0] rec_interval, rec_total;
  logic [HOUR_W-1:0] rec_hours;
  logic [5:0] rec_minutes;

  unlock_event_logger #(.CLK_HZ(1000), .DEBOUNCE_MS(4), .INTERVAL_MIN(IVL),
                        .CNT_W(CNT_W), .HOUR_W(HOUR_W)) i_unlock_event_logger (
    .clk(clk), .rst_n(rst_n), .lock_in(lock_in), .min_tick(min_tick), .rec_ready(rec_ready),
    .rec_valid(rec_valid), .rec_interval(rec_interval), .rec_total(rec_total),
    .rec_hours(rec_hours), .rec_minutes(rec_minutes));

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int q_int[$], q_tot[$], q_hr[$], q_min[$];
  int e_int = 0, e_tot = 0, e_hr = 0, e_min = 0, e_imin = 0, e_ticks = 0;
  bit pend = 0, done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string msg, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s: actual %0d expected %0d", msg, act, exp); end
  endtask

  task automatic unlock_burst();
    @(negedge clk) lock_in = 0;
    @(negedge clk) lock_in = 1;
    @(negedge clk) lock_in = 0;
    repeat (3) @(negedge clk);
    lock_in = 1;
    repeat (8) @(negedge clk);
    if (e_int < 15) e_int++;
    if (e_tot < 15) e_tot++;
  endtask

  task automatic tick();
    @(negedge clk) min_tick = 1;
    @(negedge clk) min_tick = 0;
    e_ticks++;
    e_min++;
    if (e_min == 60) begin e_min = 0; if (e_hr < 15) e_hr++; end
    e_imin++;
    if (e_imin == IVL) begin
      e_imin = 0;
      if (!pend) begin
        q_int.push_back(e_int); q_tot.push_back(e_tot);
        q_hr.push_back(e_hr); q_min.push_back(e_min);
        if (!rec_ready) pend = 1;
      end
      e_int = 0;
    end
    repeat (3) @(negedge clk);
  endtask

  always @(negedge clk) if (rst_n && rec_valid && rec_ready) begin
    if (q_int.size() == 0) check(0, "R5 unexpected record", 1, 0);
    else begin
      check(rec_interval == q_int[0], "R2 R3 R4 R5 R7 window count", rec_interval, q_int[0]);
      check(rec_total == q_tot[0], "R4 R7 total", rec_total, q_tot[0]);
      check(rec_hours == q_hr[0] && rec_minutes == q_min[0], "R6 time hh*100+mm",
            rec_hours * 100 + rec_minutes, q_hr[0] * 100 + q_min[0]);
      void'(q_int.pop_front()); void'(q_tot.pop_front());
      void'(q_hr.pop_front()); void'(q_min.pop_front());
    end
  end

  task automatic finish();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    wait (cyc == 100000);
    check(0, "watchdog expired", cyc, 0);
    finish();
  end

  initial begin
    int s_int, s_tot, s_hr, s_min;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (10) @(negedge clk);
    check(rec_valid == 0, "R1 idle after reset", rec_valid, 0);
    // R1: idle high line, first window has no events
    repeat (IVL) tick();
    // R2 R3 R4: two chattering unlocks, each one event
    unlock_burst(); unlock_burst();
    repeat (IVL) tick();
    // R7: saturation
    repeat (20) unlock_burst();
    repeat (IVL) tick();
    unlock_burst();
    repeat (IVL) tick();
    // R8: hold while consumer stalls across two window closes
    rec_ready = 0;
    unlock_burst();
    repeat (IVL) tick();
    s_int = q_int[0]; s_tot = q_tot[0]; s_hr = q_hr[0]; s_min = q_min[0];
    unlock_burst();
    repeat (IVL) tick();
    check(rec_valid == 1, "R8 record still offered", rec_valid, 1);
    check(rec_interval == s_int && rec_total == s_tot, "R8 held counts", rec_interval, s_int);
    check(rec_hours == s_hr && rec_minutes == s_min, "R8 held time", rec_minutes, s_min);
    rec_ready = 1; pend = 0;
    repeat (3) @(negedge clk);
    // R6: run through the hour rollover
    while (e_ticks < 66) tick();
    repeat (5) @(negedge clk);
    check(q_int.size() == 0, "R5 records outstanding", q_int.size(), 0);
    finish();
  end
endmodule